// File: doc/BRIEF.md
# Serial Channel Data Register with Transfer-Clock Divider

This block is the per-channel data register of a serial channel. A single 16-bit word holds two things: the low byte is the transmit/receive buffer, and the upper seven bits hold a ratio N. While the clock-select input is low, N sets the transfer clock to the operation clock divided by 2×(N+1). The operation clock is given as an enable pulse train. The ratio field is protected by the channel's run input. While the channel is running, the ratio cannot be written and reads back as zero. While the channel is stopped, a write of only the low byte also clears the ratio.

The transfer clock leaves the block as a one-cycle tick. When clock select is high, the internal divider is held in reset. Each rising edge of an external strobe then produces one tick, after the strobe passes a two-flop synchroniser. A UART-mode input makes ratios 0 and 1 illegal. A 16-bit write that carries one of them is dropped and raises an error pulse.

Top module: `chan_data_div`

## Requirements
- R1: After reset, rdata_o is 0x0000 and tick_o and err_o are 0.
- R2: With csel_i=0, run_i=1 and op_en_i high every cycle, tick_o pulses for one cycle every 2×(N+1) cycles. N is rdata bits 15:9 as last written while stopped: N=0 gives 2, N=1 gives 4, N=63 gives 128 and N=127 gives 256.
- R3: The divider counts only the cycles with op_en_i high. With op_en_i high every other cycle and N=1, the tick spacing is 8 cycles.
- R4: The divider starts from zero when run_i rises. The first tick falls in the (2N+2)-th cycle after run_i goes high, counting the cycle in which it goes high.
- R5: A 16-bit write (wr_full_i=1) while run_i=0 stores wdata_i[15:9] as N and wdata_i[7:0] as the buffer. rdata_o then returns {N, 0, buffer}.
- R6: Bit 8 always reads 0. A 1 written there is discarded.
- R7: While run_i=1, every write (16-bit or byte) updates only the buffer and leaves N unchanged.
- R8: While run_i=1, rdata_o[15:9] reads 0 and rdata_o[7:0] shows the buffer.
- R9: A byte write (wr_full_i=0) while run_i=0 stores the buffer and clears N to 0.
- R10: With uart_i=1 and run_i=0, a 16-bit write whose wdata_i[15:9] is 0 or 1 changes nothing. err_o is 1 for exactly the cycle after that write. Legal writes leave err_o at 0.
- R11: With csel_i=1 and run_i=1, each rising edge of ext_clk_i gives exactly one tick, whatever the length of the high phase. The internal divider gives no ticks.
- R12: While run_i=0, tick_o stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| op_en_i | input | 1 | Operation clock enable pulse |
| run_i | input | 1 | Channel running |
| uart_i | input | 1 | Channel used as UART (ratios 0 and 1 illegal) |
| csel_i | input | 1 | 0: internal divider, 1: external strobe |
| ext_clk_i | input | 1 | Asynchronous external clock strobe |
| wr_i | input | 1 | Write strobe |
| wr_full_i | input | 1 | 1: 16-bit write, 0: low-byte write |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data |
| err_o | output | 1 | Illegal-ratio write pulse |
| tick_o | output | 1 | Transfer clock tick |

## Verification
Tick spacing is measured for the ratios 0, 1, 63 and 127. These separate the /2 base case, the +1 offset in the formula, and the use of the full counter width up to /256. A half-rate enable pattern shows that the count follows op_en_i and not the system clock. The latency of the first tick after run_i rises shows that the counter restarts. The register is written with 16-bit and byte writes in both run states and read back, which tells the lock, read-masking and clear-on-byte-write rules apart. External strobes are applied as short pulses and as a long high level, to confirm edge-based ticking.

// File: rtl/chan_pkg.sv
package chan_pkg;
  localparam int unsigned DIV_W  = 7;
  localparam int unsigned BUF_W  = 8;
  localparam int unsigned SYNC_N = 2;
  localparam int unsigned REG_W  = DIV_W + BUF_W + 1;
  typedef enum logic [1:0] {WR_NONE, WR_BYTE, WR_FULL} wr_kind_e;
endpackage

// File: rtl/chan_dreg.sv
module chan_dreg
  import chan_pkg::*;
#(
  parameter int unsigned DW = DIV_W,
  parameter int unsigned BW = BUF_W,
  localparam int unsigned RW = DW + BW + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          run_i,
  input  logic          uart_i,
  input  logic          wr_i,
  input  logic          wr_full_i,
  input  logic [RW-1:0] wdata_i,
  output logic [DW-1:0] div_o,
  output logic [BW-1:0] buf_o,
  output logic          err_o
);
  logic [DW-1:0] div_q;
  logic [BW-1:0] buf_q;
  logic          err_q;
  logic          illegal;
  logic          unused_b8;
  wr_kind_e      kind;

  assign unused_b8 = wdata_i[BW];

  always_comb begin
    if (!wr_i)          kind = WR_NONE;
    else if (wr_full_i) kind = WR_FULL;
    else                kind = WR_BYTE;
  end

  assign illegal = uart_i && !run_i && (kind == WR_FULL)
                   && (wdata_i[RW-1 -: DW] < DW'(2));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_q <= '0;
      buf_q <= '0;
      err_q <= 1'b0;
    end else begin
      err_q <= illegal;
      if (kind != WR_NONE) begin
        if (run_i) begin
          buf_q <= wdata_i[BW-1:0];
        end else if (kind == WR_BYTE) begin
          buf_q <= wdata_i[BW-1:0];
          div_q <= '0;
        end else if (!illegal) begin
          buf_q <= wdata_i[BW-1:0];
          div_q <= wdata_i[RW-1 -: DW];
        end
      end
    end
  end

  assign div_o = div_q;
  assign buf_o = buf_q;
  assign err_o = err_q;

  // R7
  ratio_lock_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && wr_i) |=> (div_q == $past(div_q)));
  // R9
  byte_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_i && wr_i && !wr_full_i) |=> (div_q == '0));
  // R10
  err_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_q |-> (div_q == $past(div_q) && buf_q == $past(buf_q)));
endmodule

// File: rtl/chan_tick_div.sv
module chan_tick_div #(
  parameter int unsigned DW = chan_pkg::DIV_W,
  localparam int unsigned CW = DW + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic          op_en_i,
  input  logic [DW-1:0] ratio_i,
  output logic          tick_o
);
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] limit;

  assign limit  = {ratio_i, 1'b1};
  assign tick_o = en_i && op_en_i && (cnt_q == limit);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       cnt_q <= '0;
    else if (!en_i)    cnt_q <= '0;
    else if (op_en_i)  cnt_q <= (cnt_q == limit) ? '0 : cnt_q + 1'b1;
  end

  // R2
  cnt_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i |-> (cnt_q <= limit));
  // R2
  int_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |=> !tick_o);
  // R4
  restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(en_i) |-> (cnt_q == '0));
endmodule

// File: rtl/chan_ext_sync.sv
module chan_ext_sync #(
  parameter int unsigned STAGES = chan_pkg::SYNC_N
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic strobe_i,
  output logic tick_o
);
  logic [STAGES-1:0] sync_q;
  logic              last_q;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     sync_q[i] <= 1'b0;
      else if (i == 0) sync_q[i] <= strobe_i;
      else             sync_q[i] <= sync_q[(i == 0) ? 0 : i-1];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) last_q <= 1'b0;
    else         last_q <= sync_q[STAGES-1];
  end

  assign tick_o = en_i && sync_q[STAGES-1] && !last_q;

  // R11
  ext_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |=> !tick_o);
endmodule

// File: rtl/chan_data_div.sv
module chan_data_div
  import chan_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             op_en_i,
  input  logic             run_i,
  input  logic             uart_i,
  input  logic             csel_i,
  input  logic             ext_clk_i,
  input  logic             wr_i,
  input  logic             wr_full_i,
  input  logic [REG_W-1:0] wdata_i,
  output logic [REG_W-1:0] rdata_o,
  output logic             err_o,
  output logic             tick_o
);
  logic [DIV_W-1:0] div;
  logic [BUF_W-1:0] buf_val;
  logic             int_tick;
  logic             ext_tick;

  chan_dreg #(.DW(DIV_W), .BW(BUF_W)) u_dreg (
    .clk_i, .rst_ni, .run_i, .uart_i, .wr_i, .wr_full_i, .wdata_i,
    .div_o(div), .buf_o(buf_val), .err_o
  );

  chan_tick_div #(.DW(DIV_W)) u_div (
    .clk_i, .rst_ni, .en_i(run_i && !csel_i), .op_en_i,
    .ratio_i(div), .tick_o(int_tick)
  );

  chan_ext_sync #(.STAGES(SYNC_N)) u_sync (
    .clk_i, .rst_ni, .en_i(run_i && csel_i), .strobe_i(ext_clk_i),
    .tick_o(ext_tick)
  );

  assign rdata_o = {(run_i ? {DIV_W{1'b0}} : div), 1'b0, buf_val};
  assign tick_o  = csel_i ? ext_tick : int_tick;

  // R12
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |-> !tick_o);
  // R11
  sel_ext_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    csel_i |-> !int_tick);
endmodule

// File: tb/chan_data_div_tb.sv
module chan_data_div_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  logic op_en = 1'b1, run = 1'b0, uart = 1'b0, csel = 1'b0, ext = 1'b0;
  logic wr = 1'b0, wr_full = 1'b0;
  logic [15:0] wdata = '0, rdata;
  logic err, tick;
  int checks = 0, errors = 0;
  int exp_q[$];
  bit mon_en = 0, half = 0, done = 0;
  int cyc = 0, last_cyc = 0, tick_total = 0;
  bit have_last = 0;

  always #10 clk = ~clk;

  chan_data_div u_dut (
    .clk_i(clk), .rst_ni(rst_n), .op_en_i(op_en), .run_i(run), .uart_i(uart),
    .csel_i(csel), .ext_clk_i(ext), .wr_i(wr), .wr_full_i(wr_full),
    .wdata_i(wdata), .rdata_o(rdata), .err_o(err), .tick_o(tick)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #5;
  endtask

  always @(posedge clk) begin
    #5 op_en = half ? ~op_en : 1'b1;
  end

  // monitor: pops expected tick spacing
  always @(negedge clk) begin
    cyc++;
    if (tick) tick_total++;
    if (!run || !mon_en) have_last = 0;
    else if (tick && !csel) begin
      if (have_last && exp_q.size() > 0) begin
        int e;
        e = exp_q.pop_front();
        chk(cyc - last_cyc == e, "R2/R3 tick period", cyc - last_cyc, e);
      end
      last_cyc = cyc;
      have_last = 1;
    end
  end

  task automatic write(input bit full, input logic [15:0] d);
    step(); wr = 1'b1; wr_full = full; wdata = d;
    step(); wr = 1'b0;
    @(negedge clk);
  endtask

  task automatic measure(input int n, input int reps);
    write(1'b1, 16'(n << 9));
    for (int i = 0; i < reps; i++) exp_q.push_back(2 * (n + 1) * (half ? 2 : 1));
    mon_en = 1;
    step(); run = 1'b1;
    for (int i = 0; i < 4000 && exp_q.size() > 0; i++) @(negedge clk);
    chk(exp_q.size() == 0, "R2 all periods seen", exp_q.size(), 0);
    exp_q.delete();
    step(); run = 1'b0; mon_en = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int n, t0;
    #1;
    // R1
    chk(rdata == 16'h0 && !tick && !err, "R1 reset", rdata, 0);
    repeat (2) step();
    rst_n = 1'b1;
    @(negedge clk);
    chk(rdata == 16'h0 && !tick && !err, "R1 after release", rdata, 0);

    // R5, R6
    write(1'b1, 16'hA5C3);
    chk(rdata == 16'hA4C3, "R5 full write", rdata, 16'hA4C3);
    chk(rdata[8] == 1'b0, "R6 bit8 reads 0", rdata[8], 0);

    // R8, R7
    step(); run = 1'b1;
    @(negedge clk);
    chk(rdata == 16'h00C3, "R8 read while running", rdata, 16'h00C3);
    write(1'b1, 16'hFE3C);
    chk(rdata == 16'h003C, "R7 full write while running", rdata, 16'h003C);
    write(1'b0, 16'h0011);
    step(); run = 1'b0;
    @(negedge clk);
    chk(rdata == 16'hA411, "R7 ratio kept", rdata, 16'hA411);

    // R9
    write(1'b0, 16'hFF77);
    chk(rdata == 16'h0077, "R9 byte write clears ratio", rdata, 16'h0077);

    // R10
    uart = 1'b1;
    write(1'b1, 16'h0399);
    chk(err == 1'b1, "R10 err pulse", err, 1);
    chk(rdata == 16'h0077, "R10 write dropped", rdata, 16'h0077);
    @(negedge clk);
    chk(err == 1'b0, "R10 err one cycle", err, 0);
    write(1'b1, 16'h0466);
    chk(err == 1'b0 && rdata == 16'h0466, "R10 legal write", rdata, 16'h0466);
    uart = 1'b0;
    write(1'b1, 16'h0012);
    chk(rdata == 16'h0012, "R10 ratio 0 allowed outside uart", rdata, 16'h0012);

    // R12
    t0 = tick_total;
    repeat (20) @(negedge clk);
    chk(tick_total == t0, "R12 no tick when stopped", tick_total - t0, 0);

    // R2
    measure(0, 4);
    measure(1, 4);
    measure(63, 3);
    measure(127, 3);

    // R3
    half = 1;
    measure(1, 3);
    half = 0;

    // R4
    write(1'b1, 16'h0400);
    step(); run = 1'b1;
    n = 0;
    do begin @(negedge clk); n++; end while (!tick && n < 100);
    chk(n == 6, "R4 first tick after restart", n, 6);
    step(); run = 1'b0;

    // R11
    write(1'b1, 16'h0000);
    csel = 1'b1;
    step(); run = 1'b1;
    t0 = tick_total;
    for (int i = 0; i < 3; i++) begin
      step(); ext = 1'b1;
      step(); ext = 1'b0;
      repeat (6) step();
    end
    chk(tick_total - t0 == 3, "R11 one tick per pulse", tick_total - t0, 3);
    t0 = tick_total;
    step(); ext = 1'b1;
    repeat (12) step();
    ext = 1'b0;
    repeat (6) step();
    chk(tick_total - t0 == 1, "R11 long high gives one tick", tick_total - t0, 1);
    run = 1'b0; csel = 1'b0;
    repeat (2) step();

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule